// File: doc/BRIEF.md
# Adaptive Write-Policy Coherence Line Controller

This block keeps the coherence state of a small, directly indexed set of cache lines in a snooping write-back cache. Each line has a tag, a five-way state (Modified, Owned, Exclusive, Shared, Invalid), a data word and a small signed activity counter. When the local processor writes a line that other caches may also hold, the controller puts one coherence transaction on the shared bus. That transaction either kills the remote copies (invalidate) or refreshes them with the new data (update).

The choice between invalidate and update is made per write. In the adaptive policy, the line's counter is compared with a programmable threshold. The counter rises each time another cache is seen reading the line and falls each time the local core writes it. A line that others keep reading therefore drifts toward updates, and a line written mostly by one core drifts toward invalidates. Three fixed policies are also available: always invalidate, always update, and update only from the Owned state.

Misses issue a bus read and wait on a one-word fill handshake with memory. Snooped reads, invalidates and updates from other caches change local lines directly. Three running counters report the bus reads, invalidates and updates that this controller has issued.

Top module: `hybrid_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, busReq, memReq and cpuDone are low, all three traffic counters are zero, and the threshold is 1.
- R2: A read that hits returns the line data with no bus transaction. A read or write that misses issues one bus read (busType 1) and raises memReq until memValid is taken. The line is then installed Exclusive when memShared is 0 and Shared when it is 1, with data memData and counter 0.
- R3: A write to a Modified or Exclusive line issues no bus transaction and leaves the line Modified.
- R4: A write to an Owned or Shared line, or a write that missed, issues one transaction carrying the write's tag and data: an invalidate (busType 2) or an update (busType 3). The writer ends Modified after an invalidate and Owned after an update.
- R5: A snooped invalidate (snpType 2) whose tag matches a valid line makes that line Invalid.
- R6: A snooped update (snpType 3) whose tag matches a valid line replaces its data with snpData and makes it Shared.
- R7: A snooped read (snpType 1) whose tag matches a valid line adds one to its counter, saturating at +7. It also moves Modified to Owned and Exclusive to Shared.
- R8: The counter is signed 4-bit. Every completed local write subtracts one, saturating at -8 with no wrap. A write that missed counts from the fill value 0.
- R9: With policySel 0, a transaction-bearing write sends an update when counter >= threshold (signed) and an invalidate otherwise. A pulse on thrLoad loads thrValue as the new threshold.
- R10: With policySel 1 every such write sends an invalidate. With policySel 2 every such write sends an update.
- R11: With policySel 3 a write to an Owned line sends an update. A write to a Shared line, or a write that missed, sends an invalidate.
- R12: cntReadReq, cntInval and cntUpdate each add one for every bus read, invalidate and update issued.
- R13: A processor request is not accepted in a cycle with snpValid high, and a fill is not taken in a cycle with snpValid high.
- R14: A line's slot is given by the low log2(NUM_LINES) tag bits. A miss to an occupied slot replaces the old line, so a later access to the old tag misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policySel | input | 2 | Write policy: 0 adaptive, 1 invalidate-only, 2 update-only, 3 owned-only update |
| thrLoad | input | 1 | Load pulse for the threshold |
| thrValue | input | CNT_W | Signed threshold value |
| cpuValid | input | 1 | Processor request valid; held until cpuDone |
| cpuWrite | input | 1 | 1 write, 0 read |
| cpuTag | input | TAG_W | Request line tag |
| cpuWdata | input | DATA_W | Write data |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone |
| snpValid | input | 1 | Snooped transaction valid |
| snpType | input | 2 | 1 read, 2 invalidate, 3 update |
| snpTag | input | TAG_W | Snooped tag |
| snpData | input | DATA_W | Update data |
| busReq | output | 1 | One-cycle bus transaction pulse |
| busType | output | 2 | 1 read, 2 invalidate, 3 update |
| busTag | output | TAG_W | Transaction tag |
| busData | output | DATA_W | Update or write data |
| memReq | output | 1 | Fill request, high while waiting |
| memValid | input | 1 | Fill data valid; held until memReq falls |
| memShared | input | 1 | Another cache holds the line |
| memData | input | DATA_W | Fill data |
| cntReadReq | output | STAT_W | Bus reads issued |
| cntInval | output | STAT_W | Invalidates issued |
| cntUpdate | output | STAT_W | Updates issued |

## Verification
The hardest conditions to reach from the ports are the two ends of the counter's range. Reaching them takes long runs of snooped reads or silent local writes on one line, and neither run shows up at the outputs until a later write's transaction type depends on it. The bench builds each end deliberately: ten snooped reads with a threshold of 7, and twelve silent writes followed by a snooped update with thresholds of -8 and -7. Each run is then probed with a single write. A seeded sweep over all four policies and several thresholds mixes processor traffic and snoops on colliding tags. It compares every transaction type, tag, data word and read result against a line-level model kept in the bench.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_SHR = 3'd1,
    LS_EXC = 3'd2,
    LS_OWN = 3'd3,
    LS_MOD = 3'd4
  } lineState_t;

  typedef enum logic [1:0] {
    BK_NONE   = 2'd0,
    BK_READ   = 2'd1,
    BK_INVAL  = 2'd2,
    BK_UPDATE = 2'd3
  } busKind_t;

  typedef enum logic [1:0] {
    POL_THRESH = 2'd0,
    POL_INVAL  = 2'd1,
    POL_UPDATE = 2'd2,
    POL_OWNED  = 2'd3
  } policy_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       accept;       // latch request tag/data
    logic       fill;         // install memory data into the request slot
    logic       fillShared;   // install as Shared instead of Exclusive
    logic       commitWrite;  // apply a local write
    lineState_t writeState;   // state after the write
    logic       readOut;      // capture read data
    logic       issue;        // put a transaction on the bus
    busKind_t   issueKind;
  } ctlStrobe_t;

endpackage

// File: rtl/hsc_control.sv
module hsc_control
  import hsc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              policySel,
  input  logic                    thrLoad,
  input  logic signed [CNT_W-1:0] thrValue,
  input  logic                    cpuValid,
  input  logic                    cpuWrite,
  input  logic                    snpValid,
  input  logic                    memValid,
  input  logic                    memShared,
  input  logic                    lookHit,
  input  lineState_t              lookState,
  input  logic signed [CNT_W-1:0] lookCnt,
  output ctlStrobe_t              strobe,
  output logic                    cpuDone,
  output logic                    memReq
);

  typedef enum logic {FS_IDLE = 1'b0, FS_FILL = 1'b1} fsm_t;

  localparam logic signed [CNT_W-1:0] THR_RESET = {{(CNT_W-1){1'b0}}, 1'b1};

  fsm_t                    fsmQ, fsmD;
  logic                    pendWrite;
  logic signed [CNT_W-1:0] thrQ;
  policy_t                 pol;
  logic                    useUpdate;

  assign pol = policy_t'(policySel);

  function automatic logic wantUpdate(policy_t p, lineState_t st,
                                      logic signed [CNT_W-1:0] cnt,
                                      logic signed [CNT_W-1:0] thr);
    case (p)
      POL_INVAL:  return 1'b0;
      POL_UPDATE: return 1'b1;
      POL_OWNED:  return st == LS_OWN;
      default:    return cnt >= thr;
    endcase
  endfunction

  always_comb begin
    strobe    = '0;
    fsmD      = fsmQ;
    useUpdate = 1'b0;
    case (fsmQ)
      FS_IDLE: begin
        if (cpuValid && !snpValid) begin
          strobe.accept = 1'b1;
          if (lookHit) begin
            if (!cpuWrite) begin
              strobe.readOut = 1'b1;
            end else begin
              strobe.commitWrite = 1'b1;
              if (lookState == LS_MOD || lookState == LS_EXC) begin
                strobe.writeState = LS_MOD;
              end else begin
                useUpdate         = wantUpdate(pol, lookState, lookCnt, thrQ);
                strobe.issue      = 1'b1;
                strobe.issueKind  = useUpdate ? BK_UPDATE : BK_INVAL;
                strobe.writeState = useUpdate ? LS_OWN : LS_MOD;
              end
            end
          end else begin
            strobe.issue     = 1'b1;
            strobe.issueKind = BK_READ;
            fsmD             = FS_FILL;
          end
        end
      end
      default: begin
        if (memValid && !snpValid) begin
          strobe.fill       = 1'b1;
          strobe.fillShared = memShared;
          fsmD              = FS_IDLE;
          if (pendWrite) begin
            // a missed write is judged as a write from Invalid with counter 0
            useUpdate          = wantUpdate(pol, LS_INV, '0, thrQ);
            strobe.commitWrite = 1'b1;
            strobe.issue       = 1'b1;
            strobe.issueKind   = useUpdate ? BK_UPDATE : BK_INVAL;
            strobe.writeState  = useUpdate ? LS_OWN : LS_MOD;
          end else begin
            strobe.readOut = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsmQ      <= FS_IDLE;
      pendWrite <= 1'b0;
      thrQ      <= THR_RESET;
      cpuDone   <= 1'b0;
    end else begin
      fsmQ    <= fsmD;
      cpuDone <= strobe.readOut | strobe.commitWrite;
      if (strobe.accept) pendWrite <= cpuWrite;
      if (thrLoad) thrQ <= thrValue;
    end
  end

  assign memReq = (fsmQ == FS_FILL);

endmodule

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 4,
  parameter int STAT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              strobe,
  input  logic [TAG_W-1:0]        cpuTag,
  input  logic [DATA_W-1:0]       cpuWdata,
  input  logic                    snpValid,
  input  logic [1:0]              snpType,
  input  logic [TAG_W-1:0]        snpTag,
  input  logic [DATA_W-1:0]       snpData,
  input  logic [DATA_W-1:0]       memData,
  output logic                    lookHit,
  output lineState_t              lookState,
  output logic signed [CNT_W-1:0] lookCnt,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    busReq,
  output logic [1:0]              busType,
  output logic [TAG_W-1:0]        busTag,
  output logic [DATA_W-1:0]       busData,
  output logic [STAT_W-1:0]       cntReadReq,
  output logic [STAT_W-1:0]       cntInval,
  output logic [STAT_W-1:0]       cntUpdate
);

  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [STAT_W-1:0]       STAT_ONE = {{(STAT_W-1){1'b0}}, 1'b1};

  lineState_t              stQ  [NUM_LINES];
  logic [TAG_W-1:0]        tagQ [NUM_LINES];
  logic signed [CNT_W-1:0] cntQ [NUM_LINES];
  logic [DATA_W-1:0]       datQ [NUM_LINES];

  logic [TAG_W-1:0]  reqTag;
  logic [DATA_W-1:0] reqData;
  logic [TAG_W-1:0]  opTag;
  logic [DATA_W-1:0] opData;
  logic [IDX_W-1:0]  opIdx, cpuIdx;
  logic [NUM_LINES-1:0] snpMatch;
  logic signed [CNT_W-1:0] baseCnt;

  function automatic logic signed [CNT_W-1:0] satInc(logic signed [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  function automatic logic signed [CNT_W-1:0] satDec(logic signed [CNT_W-1:0] v);
    return (v == CNT_MIN) ? v : v - CNT_ONE;
  endfunction

  // during a fill the operation targets the latched request
  assign opTag  = strobe.fill ? reqTag  : cpuTag;
  assign opData = strobe.fill ? reqData : cpuWdata;
  assign opIdx  = opTag[IDX_W-1:0];
  assign cpuIdx = cpuTag[IDX_W-1:0];

  assign lookHit   = (stQ[cpuIdx] != LS_INV) && (tagQ[cpuIdx] == cpuTag);
  assign lookState = stQ[cpuIdx];
  assign lookCnt   = cntQ[cpuIdx];
  assign baseCnt   = strobe.fill ? '0 : cntQ[opIdx];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_snoopMatch
    assign snpMatch[g] = snpValid && (stQ[g] != LS_INV) && (tagQ[g] == snpTag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        stQ[i]  <= LS_INV;
        tagQ[i] <= '0;
        cntQ[i] <= '0;
        datQ[i] <= '0;
      end
    end else begin
      // snooped traffic; control never commits in a cycle with snpValid
      for (int i = 0; i < NUM_LINES; i++) begin
        if (snpMatch[i]) begin
          case (busKind_t'(snpType))
            BK_READ: begin
              cntQ[i] <= satInc(cntQ[i]);
              if (stQ[i] == LS_MOD) stQ[i] <= LS_OWN;
              else if (stQ[i] == LS_EXC) stQ[i] <= LS_SHR;
            end
            BK_INVAL: stQ[i] <= LS_INV;
            BK_UPDATE: begin
              datQ[i] <= snpData;
              stQ[i]  <= LS_SHR;
            end
            default: ;
          endcase
        end
      end
      if (strobe.fill) begin
        tagQ[opIdx] <= reqTag;
        cntQ[opIdx] <= '0;
        datQ[opIdx] <= memData;
        stQ[opIdx]  <= strobe.fillShared ? LS_SHR : LS_EXC;
      end
      if (strobe.commitWrite) begin
        datQ[opIdx] <= opData;
        stQ[opIdx]  <= strobe.writeState;
        cntQ[opIdx] <= satDec(baseCnt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqTag     <= '0;
      reqData    <= '0;
      cpuRdata   <= '0;
      busReq     <= 1'b0;
      busType    <= BK_NONE;
      busTag     <= '0;
      busData    <= '0;
      cntReadReq <= '0;
      cntInval   <= '0;
      cntUpdate  <= '0;
    end else begin
      if (strobe.accept) begin
        reqTag  <= cpuTag;
        reqData <= cpuWdata;
      end
      if (strobe.readOut) cpuRdata <= strobe.fill ? memData : datQ[opIdx];
      busReq <= strobe.issue;
      if (strobe.issue) begin
        busType <= strobe.issueKind;
        busTag  <= opTag;
        busData <= opData;
        case (strobe.issueKind)
          BK_READ:   cntReadReq <= cntReadReq + STAT_ONE;
          BK_INVAL:  cntInval   <= cntInval + STAT_ONE;
          BK_UPDATE: cntUpdate  <= cntUpdate + STAT_ONE;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/hybrid_snoop_ctrl.sv
module hybrid_snoop_ctrl
  import hsc_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 8,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 4,
  parameter int STAT_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        policySel,
  input  logic              thrLoad,
  input  logic [CNT_W-1:0]  thrValue,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpType,
  input  logic [TAG_W-1:0]  snpTag,
  input  logic [DATA_W-1:0] snpData,
  output logic              busReq,
  output logic [1:0]        busType,
  output logic [TAG_W-1:0]  busTag,
  output logic [DATA_W-1:0] busData,
  output logic              memReq,
  input  logic              memValid,
  input  logic              memShared,
  input  logic [DATA_W-1:0] memData,
  output logic [STAT_W-1:0] cntReadReq,
  output logic [STAT_W-1:0] cntInval,
  output logic [STAT_W-1:0] cntUpdate
);

  ctlStrobe_t              strobe;
  logic                    lookHit;
  lineState_t              lookState;
  logic signed [CNT_W-1:0] lookCnt;

  hsc_control #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .policySel (policySel),
    .thrLoad   (thrLoad),
    .thrValue  (thrValue),
    .cpuValid  (cpuValid),
    .cpuWrite  (cpuWrite),
    .snpValid  (snpValid),
    .memValid  (memValid),
    .memShared (memShared),
    .lookHit   (lookHit),
    .lookState (lookState),
    .lookCnt   (lookCnt),
    .strobe    (strobe),
    .cpuDone   (cpuDone),
    .memReq    (memReq)
  );

  hsc_datapath #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .STAT_W    (STAT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuTag     (cpuTag),
    .cpuWdata   (cpuWdata),
    .snpValid   (snpValid),
    .snpType    (snpType),
    .snpTag     (snpTag),
    .snpData    (snpData),
    .memData    (memData),
    .lookHit    (lookHit),
    .lookState  (lookState),
    .lookCnt    (lookCnt),
    .cpuRdata   (cpuRdata),
    .busReq     (busReq),
    .busType    (busType),
    .busTag     (busTag),
    .busData    (busData),
    .cntReadReq (cntReadReq),
    .cntInval   (cntInval),
    .cntUpdate  (cntUpdate)
  );

endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        policySel,
  input logic              cpuValid,
  input logic              cpuDone,
  input logic              snpValid,
  input logic              memReq,
  input logic              memValid,
  input logic              busReq,
  input logic [1:0]        busType,
  input logic [STAT_W-1:0] cntReadReq,
  input logic [STAT_W-1:0] cntInval,
  input logic [STAT_W-1:0] cntUpdate
);

  localparam logic [STAT_W-1:0] ONE = {{(STAT_W-1){1'b0}}, 1'b1};

  assert_read_opens_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busType == 2'd1) |-> memReq)
    else $error("bus read without pending fill");

  assert_fill_releases_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memValid && !snpValid) |=> !memReq)
    else $error("fill not released after data");

  assert_kind_present_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busType != 2'd0)
    else $error("bus pulse with empty kind");

  assert_no_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && $past(policySel) == 2'd1) |-> busType != 2'd3)
    else $error("update under invalidate-only policy");

  assert_no_inval_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && $past(policySel) == 2'd2) |-> busType != 2'd2)
    else $error("invalidate under update-only policy");

  assert_read_counted_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busType == 2'd1) |-> cntReadReq == $past(cntReadReq) + ONE)
    else $error("bus read not counted");

  assert_update_counted_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busType == 2'd3) |-> cntUpdate == $past(cntUpdate) + ONE)
    else $error("update not counted");

  assert_idle_counts_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> ($stable(cntInval) && $stable(cntUpdate) && $stable(cntReadReq)))
    else $error("counter moved without traffic");

  assert_snoop_stalls_cpu_R13: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && snpValid && !memReq) |=> !cpuDone)
    else $error("request accepted during snoop");

endmodule

bind hybrid_snoop_ctrl hsc_checker #(.STAT_W(STAT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .policySel  (policySel),
  .cpuValid   (cpuValid),
  .cpuDone    (cpuDone),
  .snpValid   (snpValid),
  .memReq     (memReq),
  .memValid   (memValid),
  .busReq     (busReq),
  .busType    (busType),
  .cntReadReq (cntReadReq),
  .cntInval   (cntInval),
  .cntUpdate  (cntUpdate)
);

// File: tb/hybrid_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hybrid_snoop_ctrl_tb_top;
  localparam int NL = 4, TW = 8, DW = 16, CW = 4, SW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic [1:0] policySel = 2'd0;
  logic thrLoad = 1'b0;
  logic [CW-1:0] thrValue = '0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [TW-1:0] cpuTag = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuDone;
  logic [DW-1:0] cpuRdata;
  logic snpValid = 1'b0;
  logic [1:0] snpType = 2'd0;
  logic [TW-1:0] snpTag = '0;
  logic [DW-1:0] snpData = '0;
  logic busReq;
  logic [1:0] busType;
  logic [TW-1:0] busTag;
  logic [DW-1:0] busData;
  logic memReq;
  logic memValid = 1'b0, memShared = 1'b0;
  logic [DW-1:0] memData = '0;
  logic [SW-1:0] cntReadReq, cntInval, cntUpdate;

  hybrid_snoop_ctrl #(.NUM_LINES(NL), .TAG_W(TW), .DATA_W(DW), .CNT_W(CW), .STAT_W(SW)) dut_i (
    .clk(clk), .rstN(rstN), .policySel(policySel), .thrLoad(thrLoad), .thrValue(thrValue),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuTag(cpuTag), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuRdata(cpuRdata), .snpValid(snpValid), .snpType(snpType),
    .snpTag(snpTag), .snpData(snpData), .busReq(busReq), .busType(busType),
    .busTag(busTag), .busData(busData), .memReq(memReq), .memValid(memValid),
    .memShared(memShared), .memData(memData), .cntReadReq(cntReadReq),
    .cntInval(cntInval), .cntUpdate(cntUpdate));

  int checks = 0, fails = 0;
  // line model: state 0 I, 1 S, 2 E, 3 O, 4 M
  int mState[NL], mTag[NL], mCnt[NL], mData[NL];
  int mPol = 0, mThr = 1;
  int nRd = 0, nInv = 0, nUpd = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int fillVal(int t);
    return (t * 4951 + 165) & 16'hffff;
  endfunction

  task automatic setPolicy(int p, int thr);
    @(negedge clk);
    policySel = 2'(p);
    thrLoad = 1'b1;
    thrValue = CW'(thr);
    @(negedge clk);
    thrLoad = 1'b0;
    mPol = p;
    mThr = thr;
  endtask

  task automatic snoop(int kind, int t, int d);
    int idx = t % NL;
    @(negedge clk);
    snpValid = 1'b1; snpType = 2'(kind); snpTag = TW'(t); snpData = DW'(d);
    @(negedge clk);
    snpValid = 1'b0;
    if (mState[idx] != 0 && mTag[idx] == t) begin
      if (kind == 1) begin
        if (mCnt[idx] < 7) mCnt[idx]++;
        if (mState[idx] == 4) mState[idx] = 3;
        else if (mState[idx] == 2) mState[idx] = 1;
      end else if (kind == 2) mState[idx] = 0;
      else if (kind == 3) begin mData[idx] = d & 16'hffff; mState[idx] = 1; end
    end
  endtask

  task automatic doOp(string req, bit wr, int t, int d, bit shared);
    int idx = t % NL;
    bit hit, expMiss, upd = 1'b0, done = 1'b0, sawMiss = 1'b0;
    int expKind = 0, expR = 0, st, cnt, sawKind = 0, sawTag = 0, sawData = 0, rd = 0;
    hit = (mState[idx] != 0) && (mTag[idx] == t);
    expMiss = !hit;
    if (!hit) begin
      mTag[idx] = t; mData[idx] = fillVal(t); mCnt[idx] = 0; mState[idx] = shared ? 1 : 2;
      nRd++;
    end
    if (!wr) expR = mData[idx];
    else begin
      st = hit ? mState[idx] : 0;
      cnt = mCnt[idx];
      if (st == 4 || st == 2) mState[idx] = 4;
      else begin
        case (mPol)
          1: upd = 1'b0;
          2: upd = 1'b1;
          3: upd = (st == 3);
          default: upd = (cnt >= mThr);
        endcase
        expKind = upd ? 3 : 2;
        if (upd) nUpd++; else nInv++;
        mState[idx] = upd ? 3 : 4;
      end
      mCnt[idx] = (cnt > -8) ? cnt - 1 : -8;
      mData[idx] = d & 16'hffff;
    end
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuTag = TW'(t); cpuWdata = DW'(d);
    for (int c = 0; c < 40 && !done; c++) begin
      @(negedge clk);
      if (busReq) begin
        if (busType == 2'd1) sawMiss = 1'b1;
        else begin sawKind = busType; sawTag = busTag; sawData = busData; end
      end
      if (cpuDone) begin done = 1'b1; rd = cpuRdata; memValid = 1'b0; end
      else if (memReq && !memValid) begin
        memValid = 1'b1; memData = DW'(fillVal(t)); memShared = shared;
      end else memValid = 1'b0;
    end
    cpuValid = 1'b0;
    check(req, "completion", done, 1);
    check(req, "miss bus read (R2/R14)", sawMiss, expMiss);
    check(req, "write transaction kind", sawKind, expKind);
    if (!wr) check(req, "read data", rd, expR);
    if (expKind != 0) begin
      check(req, "transaction tag", sawTag, t);
      check(req, "transaction data", sawData, d & 16'hffff);
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned r = 32'h1badf00d;
    for (int i = 0; i < NL; i++) begin mState[i] = 0; mTag[i] = 0; mCnt[i] = 0; mData[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1", "busReq", busReq, 0);
    check("R1", "memReq", memReq, 0);
    check("R1", "cpuDone", cpuDone, 0);
    check("R1", "counters", cntReadReq + cntInval + cntUpdate, 0);
    // R1 threshold of 1: counter 1 reaches it
    doOp("R2", 0, 0, 0, 0);            // fill Exclusive, cnt 0
    snoop(1, 0, 0);                    // R7 E->S, cnt 1
    doOp("R1", 1, 0, 16'h1111, 0);     // update at threshold 1 -> Owned
    // R9 threshold 2 rejects counter 1
    setPolicy(0, 2);
    doOp("R2", 0, 6, 0, 1);            // fill Shared
    snoop(1, 6, 0);
    doOp("R9", 1, 6, 16'h2222, 0);     // invalidate
    // R3 silent writes on Exclusive then Modified
    doOp("R2", 0, 1, 0, 0);
    doOp("R3", 1, 1, 16'h3333, 0);
    doOp("R3", 1, 1, 16'h3334, 0);
    // R7 M->O then R11 owned-only update, then update-only/inval-only
    snoop(1, 1, 0);
    setPolicy(3, 1);
    doOp("R11", 1, 1, 16'h4444, 0);    // Owned -> update
    doOp("R11", 1, 6, 16'h4445, 1);    // Modified -> silent
    doOp("R11", 1, 9, 16'h4446, 1);    // miss, slot 1 replaced -> invalidate
    // R5 snooped invalidate then re-read misses
    snoop(2, 9, 0);
    doOp("R5", 0, 9, 0, 1);
    // R6 snooped update, data then write transacts
    setPolicy(2, 1);
    snoop(3, 9, 16'h5a5a);
    doOp("R6", 0, 9, 0, 0);
    doOp("R6", 1, 9, 16'h6666, 0);     // R10 update-only
    setPolicy(1, 1);
    snoop(1, 9, 0);
    doOp("R10", 1, 9, 16'h6667, 0);    // Owned, inval-only -> invalidate
    // R14 slot replacement
    doOp("R14", 0, 3, 0, 0);
    doOp("R14", 0, 7, 0, 0);
    doOp("R14", 0, 3, 0, 0);
    // R13 snoop beats cpu request in the same cycle
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuTag = TW'(3);
    snpValid = 1'b1; snpType = 2'd2; snpTag = TW'(3);
    @(negedge clk);
    check("R13", "cpuDone during snoop", cpuDone, 0);
    cpuValid = 1'b0; snpValid = 1'b0;
    mState[3] = 0;
    doOp("R13", 0, 3, 0, 0);
    // R7/R8 upper saturation with threshold 7
    setPolicy(0, 7);
    doOp("R8", 0, 2, 0, 0);
    for (int k = 0; k < 10; k++) snoop(1, 2, 0);
    doOp("R7", 1, 2, 16'h7777, 0);     // 7 >= 7 -> update
    doOp("R8", 1, 2, 16'h7778, 0);     // 6 < 7 -> invalidate
    // R8 lower saturation without wrap
    doOp("R8", 0, 11, 0, 0);
    for (int k = 0; k < 12; k++) doOp("R3", 1, 11, k, 0);
    snoop(3, 11, 16'h0bad);
    setPolicy(0, -8);
    doOp("R8", 1, 11, 16'h8888, 0);    // -8 >= -8 -> update
    setPolicy(0, -7);
    doOp("R8", 1, 11, 16'h8889, 0);    // -8 < -7 -> invalidate
    // seeded sweep over policies and thresholds
    for (int p = 0; p < 4; p++) begin
      for (int th = -1; th < 3; th++) begin
        setPolicy(p, th);
        for (int n = 0; n < 50; n++) begin
          int op, t;
          r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
          op = int'(r % 8);
          t = int'((r >> 4) % 8);
          if (op < 3) doOp(p == 0 ? "R9" : (p == 3 ? "R11" : "R10"), 0, t, 0, r[9]);
          else if (op < 5) doOp(p == 0 ? "R9" : (p == 3 ? "R11" : "R10"), 1, t, int'(r >> 16), r[9]);
          else snoop(op - 4, t, int'(r >> 12));
        end
      end
    end
    @(negedge clk);
    check("R12", "read count", cntReadReq, nRd);
    check("R12", "invalidate count", cntInval, nInv);
    check("R12", "update count", cntUpdate, nUpd);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule